// File: doc/BRIEF.md
# Serial Status-and-Data Receive Deserializer

This block turns the single-wire receive stream of one PHY port on a serial media-independent interface into parallel status and data. Every receive clock carries one bit. A high pulse on the sync line marks the first bit of a ten-bit segment. The first two bits of a segment report carrier sense and receive data-valid. The last eight bits are a data byte, sent least-significant bit first.

The block counts bit slots from the sync pulse, collects the segment and registers the result on the edge that samples its last bit. Carrier sense and data-valid are refreshed once per segment. A byte strobe fires for one cycle when the segment marks its byte as valid. A sync pulse at the wrong slot, or a missing one where it is due, raises a one-cycle error flag and forces alignment again. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `serial_rx_deser`

## Requirements
- R1: While reset is asserted, and after it is released, crs_o, dv_o, byte_o, byte_stb_o and sync_err_o are all 0.
- R2: Until the first sync pulse after reset, the data line is ignored: all outputs stay 0 and byte_stb_o never rises.
- R3: The bit sampled together with the sync pulse is segment bit 0, carrier sense. Bit 1 is data-valid. Bits 2 to 9 are the data byte, with bit 2 as byte bit 0 and bit 9 as byte bit 7.
- R4: crs_o and dv_o take the values of the completed segment on the clock edge that samples segment bit 9. They keep those values until the next segment completes.
- R5: byte_stb_o is high for exactly the one cycle after a completed segment whose data-valid bit is 1. byte_o is loaded only in that case and otherwise keeps its value.
- R6: A sync pulse at any slot other than 0 pulses sync_err_o for one cycle and throws away the partial segment. A new segment starts at that bit.
- R7: When aligned and slot 0 is due but sync is low, sync_err_o pulses for one cycle and alignment is lost. Later bits are ignored, with outputs held and no strobe, until the next sync pulse.
- R8: Segments that follow back to back, with sync every ten clocks, are each decoded, with no error and no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock; one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sync | input | 1 | Segment start strobe, high with segment bit 0 |
| rx_bit | input | 1 | Serial receive data line |
| crs_o | output | 1 | Carrier sense of the last completed segment |
| dv_o | output | 1 | Data-valid of the last completed segment |
| byte_o | output | 8 | Last byte received with data-valid set |
| byte_stb_o | output | 1 | One-cycle pulse when byte_o has been loaded |
| sync_err_o | output | 1 | One-cycle pulse on a misplaced or missing sync |

## Verification
The assertions assume that rx_sync and rx_bit are settled around each rising clock edge. They also assume that, once aligned, sync pulses normally recur every ten clocks. Errors come only from deliberate early or missing pulses. The bench changes inputs only on falling edges. Its random stimulus sends whole segments with sync on bit 0. The only deviations are directed ones: segments cut short by an early sync, a withheld sync followed by unsynchronized bits, and idle bits before the first sync.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int STATUS_BITS = 2;

  typedef struct packed {
    logic dv;
    logic crs;
  } srx_status_t;
endpackage

// File: rtl/srx_rst_sync.sv
module srx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/srx_slot.sv
module srx_slot #(
  parameter int SEG_BITS = 10,
  localparam int CNT_W = $clog2(SEG_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  output logic             take_o,
  output logic [CNT_W-1:0] slot_o,
  output logic             last_o,
  output logic             aligned_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SEG_BITS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             aligned_q, aligned_nxt;
  logic             err_q, err_nxt;
  logic             early, missing, mid;

  always_comb begin
    mid     = aligned_q && (cnt_q != '0);
    early   = sync_i && mid;
    missing = !sync_i && aligned_q && (cnt_q == '0);
    take_o  = sync_i || mid;
    slot_o  = sync_i ? '0 : cnt_q;
    last_o  = take_o && (slot_o == LAST_SLOT);

    cnt_nxt = cnt_q;
    if (sync_i) begin
      cnt_nxt = CNT_W'(1);
    end else if (mid) begin
      cnt_nxt = (cnt_q == LAST_SLOT) ? '0 : cnt_q + CNT_W'(1);
    end

    aligned_nxt = aligned_q;
    if (sync_i) begin
      aligned_nxt = 1'b1;
    end else if (missing) begin
      aligned_nxt = 1'b0;
    end

    err_nxt = early || missing;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      aligned_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      cnt_q     <= cnt_nxt;
      aligned_q <= aligned_nxt;
      err_q     <= err_nxt;
    end
  end

  assign aligned_o = aligned_q;
  assign err_o     = err_q;

  assert_slot_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_SLOT);

  assert_lose_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned_q && (cnt_q == '0) && !sync_i) |=> (!aligned_q && err_q));

  assert_early_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && aligned_q && (cnt_q != '0)) |=> (err_q && (cnt_q == CNT_W'(1))));
endmodule

// File: rtl/srx_capture.sv
module srx_capture #(
  parameter int DATA_BITS = 8,
  parameter int SEG_BITS = DATA_BITS + srx_pkg::STATUS_BITS,
  localparam int CNT_W = $clog2(SEG_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take_i,
  input  logic [CNT_W-1:0]     slot_i,
  input  logic                 last_i,
  input  logic                 bit_i,
  output srx_pkg::srx_status_t status_o,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 stb_o
);
  localparam int HOLD_BITS = SEG_BITS - 1;

  logic [HOLD_BITS-1:0] seg_q, seg_nxt;
  logic [SEG_BITS-1:0]  full;
  srx_pkg::srx_status_t status_q, status_nxt;
  logic [DATA_BITS-1:0] byte_q, byte_nxt;
  logic                 stb_q, stb_nxt;

  for (genvar i = 0; i < HOLD_BITS; i++) begin : g_slot
    always_comb begin
      seg_nxt[i] = (take_i && (slot_i == CNT_W'(i))) ? bit_i : seg_q[i];
    end
  end

  always_comb begin
    full       = {bit_i, seg_q};
    status_nxt = status_q;
    byte_nxt   = byte_q;
    stb_nxt    = 1'b0;
    if (last_i) begin
      status_nxt.crs = full[0];
      status_nxt.dv  = full[1];
      if (full[1]) begin
        byte_nxt = full[SEG_BITS-1:srx_pkg::STATUS_BITS];
        stb_nxt  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q    <= '0;
      status_q <= '0;
      byte_q   <= '0;
      stb_q    <= 1'b0;
    end else begin
      seg_q    <= seg_nxt;
      status_q <= status_nxt;
      byte_q   <= byte_nxt;
      stb_q    <= stb_nxt;
    end
  end

  assign status_o = status_q;
  assign byte_o   = byte_q;
  assign stb_o    = stb_q;

  assert_byte_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_q |-> $stable(byte_q));
endmodule

// File: rtl/serial_rx_deser.sv
module serial_rx_deser #(
  parameter int DATA_BITS = 8,
  localparam int SEG_BITS = DATA_BITS + srx_pkg::STATUS_BITS,
  localparam int CNT_W = $clog2(SEG_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_sync,
  input  logic                 rx_bit,
  output logic                 crs_o,
  output logic                 dv_o,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 byte_stb_o,
  output logic                 sync_err_o
);
  logic                 rst_sync_n;
  logic                 take;
  logic [CNT_W-1:0]     slot;
  logic                 last;
  logic                 aligned;
  srx_pkg::srx_status_t status;

  srx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  srx_slot #(.SEG_BITS(SEG_BITS)) u_slot (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sync_i    (rx_sync),
    .take_o    (take),
    .slot_o    (slot),
    .last_o    (last),
    .aligned_o (aligned),
    .err_o     (sync_err_o)
  );

  srx_capture #(.DATA_BITS(DATA_BITS), .SEG_BITS(SEG_BITS)) u_cap (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .take_i   (take),
    .slot_i   (slot),
    .last_i   (last),
    .bit_i    (rx_bit),
    .status_o (status),
    .byte_o   (byte_o),
    .stb_o    (byte_stb_o)
  );

  assign crs_o = status.crs;
  assign dv_o  = status.dv;

  assert_stb_needs_align_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    byte_stb_o |-> ($past(aligned) || $past(rx_sync)));

  assert_stb_single_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    byte_stb_o |=> !byte_stb_o);

  assert_stb_has_dv_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    byte_stb_o |-> dv_o);

  assert_status_hold_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$past(last) |-> ($stable(crs_o) && $stable(dv_o)));
endmodule

// File: tb/test_serial_rx_deser.sv
module test_serial_rx_deser;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_sync;
  logic       rx_bit;
  logic       crs_o, dv_o, byte_stb_o, sync_err_o;
  logic [7:0] byte_o;

  int checks = 0;
  int errors = 0;

  logic       m_crs, m_dv, m_stb, pending, exp_err;
  logic [7:0] m_byte;

  always #5 clk = ~clk;

  serial_rx_deser i_serial_rx_deser (
    .clk(clk), .rst_n(rst_n), .rx_sync(rx_sync), .rx_bit(rx_bit),
    .crs_o(crs_o), .dv_o(dv_o), .byte_o(byte_o),
    .byte_stb_o(byte_stb_o), .sync_err_o(sync_err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic chk_held(input string req);
    chk(crs_o == m_crs, req, crs_o, m_crs);
    chk(dv_o == m_dv, req, dv_o, m_dv);
    chk(byte_o == m_byte, req, byte_o, m_byte);
  endtask

  function automatic logic seg_bit(input logic c, input logic d, input logic [7:0] b, input int i);
    if (i == 0) return c;
    if (i == 1) return d;
    return b[i-2];
  endfunction

  // Complete segment with sync on bit 0 (R3, R4, R5, R8).
  task automatic send_seg(input logic c, input logic d, input logic [7:0] b);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i == 0 && pending) begin
        chk_held("R3 R4 segment decode");
        chk(byte_stb_o == m_stb, "R5 strobe", byte_stb_o, m_stb);
        chk(sync_err_o == 1'b0, "R8 no error", sync_err_o, 0);
      end
      if (i == 1) begin
        chk(byte_stb_o == 1'b0, "R5 strobe one cycle", byte_stb_o, 0);
        chk(sync_err_o == exp_err, "R6 sync error flag", sync_err_o, exp_err);
        chk_held("R4 status held");
        exp_err = 1'b0;
      end
      rx_sync = (i == 0);
      rx_bit  = seg_bit(c, d, b, i);
    end
    m_crs = c;
    m_dv  = d;
    if (d) m_byte = b;
    m_stb   = d;
    pending = 1'b1;
  endtask

  // First k bits of a segment, to be cut short by an early sync (R6).
  task automatic send_partial(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (i == 0 && pending) begin
        chk_held("R3 R4 segment decode");
        chk(byte_stb_o == m_stb, "R5 strobe", byte_stb_o, m_stb);
      end else begin
        chk(byte_stb_o == 1'b0, "R6 no strobe in partial", byte_stb_o, 0);
      end
      rx_sync = (i == 0);
      rx_bit  = 1'b1;
    end
    pending = 1'b0;
  endtask

  // Bits with sync held low; outputs must not move (R2, R7).
  task automatic send_raw(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0 && pending) begin
        chk_held("R3 R4 segment decode");
        chk(byte_stb_o == m_stb, "R5 strobe", byte_stb_o, m_stb);
      end else begin
        chk_held(req);
        chk(byte_stb_o == 1'b0, req, byte_stb_o, 0);
      end
      if (i == 1) begin
        chk(sync_err_o == exp_err, "R7 missing sync flag", sync_err_o, exp_err);
        exp_err = 1'b0;
      end else if (i > 1) begin
        chk(sync_err_o == 1'b0, "R7 single error pulse", sync_err_o, 0);
      end
      rx_sync = 1'b0;
      rx_bit  = 1'($urandom);
    end
    pending = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5A17));
    m_crs = 0; m_dv = 0; m_byte = 0; m_stb = 0; pending = 0; exp_err = 0;
    rst_n = 1'b0; rx_sync = 1'b0; rx_bit = 1'b1;
    repeat (3) @(negedge clk);
    chk(crs_o == 0 && dv_o == 0 && byte_o == 0, "R1 reset outputs", {crs_o, dv_o, byte_o}, 0);
    chk(byte_stb_o == 0 && sync_err_o == 0, "R1 reset pulses", {byte_stb_o, sync_err_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(crs_o == 0 && byte_stb_o == 0 && sync_err_o == 0, "R1 after release", {crs_o, byte_stb_o, sync_err_o}, 0);

    send_raw(25, "R2 ignored before sync");

    send_seg(1'b1, 1'b1, 8'h01);
    send_seg(1'b1, 1'b1, 8'h80);
    send_seg(1'b0, 1'b0, 8'hFF);
    send_seg(1'b1, 1'b0, 8'h3C);
    send_seg(1'b1, 1'b1, 8'hA5);

    for (int n = 0; n < 150; n++) begin
      send_seg(1'($urandom), 1'($urandom), 8'($urandom));
    end

    for (int k = 1; k < 10; k += 4) begin
      send_partial(k);
      exp_err = 1'b1;
      send_seg(1'b1, 1'b1, 8'($urandom));
    end

    send_seg(1'b0, 1'b1, 8'h5A);
    exp_err = 1'b1;
    send_raw(30, "R7 ignored after loss");
    send_seg(1'b1, 1'b1, 8'hC3);
    send_seg(1'b0, 1'b0, 8'h00);
    exp_err = 1'b1;
    send_raw(5, "R7 ignored after loss");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule